// File: doc/BRIEF.md
# Memory Ordering Serialization Controller

This block sits beside the issue stage of an in-order processor and carries out three barrier instructions of different strength. A full synchronize holds every later instruction until the machine is empty. It then waits for earlier memory traffic to be globally performed and for the barrier to be announced on the external bus. An I/O ordering barrier holds only later loads and stores until the earlier ones have finished, and it is also announced on the bus. A fetch synchronize halts instruction fetch until every issued instruction and every prefetched instruction waiting in the buffer has completed.

The issue stage presents the decoded class of the instruction it is about to issue. The rest of the core supplies occupancy counts, a prefetch-buffer flag and two acknowledgements. The controller answers with a general issue stall, a load/store issue stall, a fetch halt and a bus broadcast request. A small state machine walks through draining, waiting for global performance, broadcasting and release. Only one barrier is in progress at a time.

Top module: `mem_barrier_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no barrier presented, stall_all, stall_ldst, fetch_halt and bus_req are all low.
- R2: issue_class encodes 00 as an ordinary instruction, 01 as full synchronize, 10 as I/O ordering barrier and 11 as fetch synchronize. A barrier is accepted when issue_valid is high, the class is non-zero and no barrier is in progress. Its stall outputs rise in the cycle after acceptance, and an ordinary instruction raises no output.
- R3: After a full synchronize is accepted, stall_all and stall_ldst stay high until inflight_cnt is zero with prefetch_pending low, then global_done is seen, then bus_ack is seen, in that order.
- R4: During a full synchronize, global_done has no effect before the pipeline has drained, and bus_req stays low until global_done has been seen after the drain.
- R5: After an I/O ordering barrier is accepted, stall_ldst is high and stall_all is low. Once ldst_cnt reads zero, bus_req is raised without waiting for global_done, and stall_ldst holds until bus_ack.
- R6: After a fetch synchronize is accepted, fetch_halt is high, stall_all and bus_req are low, and the halt holds until inflight_cnt is zero with prefetch_pending low.
- R7: bus_req stays high in every cycle until a cycle in which bus_ack is high, and is low in the following cycle.
- R8: Each stall or halt output falls in the cycle after the last of its conditions is met. A new barrier presented in that cycle is accepted at once.
- R9: A barrier presented while another is in progress is not accepted. In that cycle stall_all is high so that it is held at issue, and it is accepted once the current barrier has released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is at issue |
| issue_class | input | 2 | Decoded class of the instruction at issue |
| inflight_cnt | input | CNT_W | Earlier instructions not yet completed |
| ldst_cnt | input | CNT_W | Earlier loads and stores not yet completed |
| prefetch_pending | input | 1 | Prefetched instructions wait in the buffer |
| global_done | input | 1 | Earlier memory accesses are globally performed |
| bus_ack | input | 1 | Bus broadcast of the barrier has completed |
| stall_all | output | 1 | Hold every instruction at issue |
| stall_ldst | output | 1 | Hold loads and stores at issue |
| fetch_halt | output | 1 | Halt instruction fetch |
| bus_req | output | 1 | Request a barrier broadcast on the bus |

## Verification
Two events can fall in the same cycle: the release of one barrier and the arrival of the next barrier at issue. A second barrier can also arrive while the first is still in progress, which makes the hold stall coincide with the barrier's own stalls. Directed sequences present a new barrier in the exact release cycle and in the middle of a running I/O barrier. Random stimulus fires issue, drain, global and acknowledge inputs together often. Every cycle, a reference state machine in the bench, built from the requirements, predicts all four outputs and judges the controller against them.

// File: rtl/mem_barrier_ctrl.sv
module mem_barrier_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [1:0]       issue_class,
  input  logic [CNT_W-1:0] inflight_cnt,
  input  logic [CNT_W-1:0] ldst_cnt,
  input  logic             prefetch_pending,
  input  logic             global_done,
  input  logic             bus_ack,
  output logic             stall_all,
  output logic             stall_ldst,
  output logic             fetch_halt,
  output logic             bus_req
);

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_WGLOB, S_BCAST, S_REL} st_t;
  typedef enum logic [1:0] {K_NONE, K_FULL, K_IO, K_FETCH} kind_t;

  st_t   st, st_nx;
  kind_t kind;

  logic ready, take, busy, pipe_empty;

  assign ready      = (st == S_IDLE) || (st == S_REL);
  assign busy       = !ready;
  assign take       = ready && issue_valid && (issue_class != 2'b00);
  assign pipe_empty = (inflight_cnt == '0) && !prefetch_pending;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE, S_REL: st_nx = take ? S_DRAIN : S_IDLE;
      S_DRAIN: begin
        case (kind)
          K_FULL:  if (pipe_empty)      st_nx = S_WGLOB;
          K_IO:    if (ldst_cnt == '0)  st_nx = S_BCAST;
          K_FETCH: if (pipe_empty)      st_nx = S_REL;
          default:                      st_nx = S_REL;
        endcase
      end
      S_WGLOB: if (global_done) st_nx = S_BCAST;
      S_BCAST: if (bus_ack)     st_nx = S_REL;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      kind <= K_NONE;
    end else begin
      st <= st_nx;
      if (take) kind <= kind_t'(issue_class);
    end
  end

  assign stall_all  = (busy && kind == K_FULL) ||
                      (busy && issue_valid && issue_class != 2'b00);
  assign stall_ldst = busy && (kind == K_FULL || kind == K_IO);
  assign fetch_halt = busy && (kind == K_FETCH);
  assign bus_req    = (st == S_BCAST);

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req); // R7
  AST_BUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req); // R7
  AST_FETCH_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_halt |-> !bus_req); // R6
  AST_IO_LDST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_ldst && !bus_req && kind == K_IO && ldst_cnt != '0) |=> stall_ldst); // R5
  AST_ONE_BARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_halt, stall_ldst})); // R9

endmodule

// File: tb/mem_barrier_ctrl_tb.sv
`timescale 1ns/1ps
module mem_barrier_ctrl_tb;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv = 1'b0;
  logic [1:0] cls = 2'b00;
  logic [CW-1:0] infl = '0, ldst = '0;
  logic pf = 1'b0, gd = 1'b0, ack = 1'b0;
  logic o_all, o_ldst, o_fh, o_bus;

  int total = 0, bad = 0;
  int m_st = 0;
  int m_kind = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  mem_barrier_ctrl #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(iv), .issue_class(cls),
    .inflight_cnt(infl), .ldst_cnt(ldst), .prefetch_pending(pf),
    .global_done(gd), .bus_ack(ack),
    .stall_all(o_all), .stall_ldst(o_ldst), .fetch_halt(o_fh), .bus_req(o_bus)
  );

  task automatic chk(input logic act, input logic exp, input string t, input string nm);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", t, nm, act, exp, $time);
    end
  endtask

  function automatic logic active();
    return m_st == 1 || m_st == 2 || m_st == 3;
  endfunction

  task automatic compare_all();
    logic e_all, e_ldst, e_fh, e_bus;
    e_all  = (active() && m_kind == 1) || (active() && iv && cls != 2'b00);
    e_ldst = active() && (m_kind == 1 || m_kind == 2);
    e_fh   = active() && m_kind == 3;
    e_bus  = m_st == 3;
    chk(o_all,  e_all,  tag, "stall_all");
    chk(o_ldst, e_ldst, tag, "stall_ldst");
    chk(o_fh,   e_fh,   tag, "fetch_halt");
    chk(o_bus,  e_bus,  tag, "bus_req");
  endtask

  task automatic model_edge();
    logic empty;
    empty = (infl == 0) && !pf;
    case (m_st)
      0, 4: if (iv && cls != 2'b00) begin m_st = 1; m_kind = int'(cls); end else m_st = 0;
      1: begin
        if (m_kind == 1 && empty) m_st = 2;
        else if (m_kind == 2 && ldst == 0) m_st = 3;
        else if (m_kind == 3 && empty) m_st = 4;
      end
      2: if (gd) m_st = 3;
      3: if (ack) m_st = 4;
      default: m_st = 0;
    endcase
  endtask

  task automatic step(input logic v, input logic [1:0] c, input int fi, input int ls,
                      input logic p, input logic g, input logic a);
    @(negedge clk);
    iv = v; cls = c; infl = CW'(fi); ldst = CW'(ls); pf = p; gd = g; ack = a;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    chk(o_all, 1'b0, "R1", "stall_all");
    chk(o_ldst, 1'b0, "R1", "stall_ldst");
    chk(o_fh, 1'b0, "R1", "fetch_halt");
    chk(o_bus, 1'b0, "R1", "bus_req");
    rst_n = 1'b1;
    step(0, 2'b00, 0, 0, 0, 0, 0);

    // R2: ordinary instruction raises nothing
    tag = "R2";
    step(1, 2'b00, 3, 2, 1, 1, 1);
    step(0, 2'b00, 3, 2, 1, 1, 1);

    // R3/R4: full synchronize, ordered conditions
    tag = "R3";
    step(1, 2'b01, 3, 2, 1, 0, 0);
    tag = "R4";
    step(0, 2'b00, 2, 1, 0, 1, 1);
    step(0, 2'b00, 0, 0, 1, 1, 0);
    step(0, 2'b00, 0, 0, 0, 0, 1);
    step(0, 2'b00, 0, 0, 0, 0, 1);
    step(0, 2'b00, 0, 0, 0, 1, 0);
    tag = "R7";
    step(0, 2'b00, 0, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0, 1);
    tag = "R8";
    step(0, 2'b00, 0, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0, 0);

    // R5: I/O barrier, with R9 hold of a second barrier
    tag = "R5";
    step(1, 2'b10, 4, 2, 1, 0, 0);
    step(1, 2'b00, 4, 2, 1, 0, 0);
    tag = "R9";
    step(1, 2'b01, 4, 1, 1, 0, 0);
    tag = "R5";
    step(0, 2'b00, 4, 0, 1, 0, 0);
    step(0, 2'b00, 4, 0, 1, 0, 0);
    step(0, 2'b00, 4, 0, 1, 0, 1);
    // R8: new barrier accepted in the release cycle
    tag = "R8";
    step(1, 2'b11, 2, 0, 1, 0, 0);
    tag = "R6";
    step(0, 2'b00, 2, 0, 1, 1, 1);
    step(0, 2'b00, 0, 0, 1, 1, 1);
    step(0, 2'b00, 0, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 0, 0, 0);

    // Random mix
    tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      logic v;
      logic [1:0] c;
      int fi, ls;
      v  = ($urandom % 4) == 0;
      c  = 2'($urandom % 4);
      fi = ($urandom % 2) ? 0 : int'($urandom % 8);
      ls = ($urandom % 2) ? 0 : int'($urandom % 8);
      step(v, c, fi, ls, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule